// File: doc/BRIEF.md
# Display Source Priority Selector

This block decides, on every clock, which value a 4.5-digit segment display should show. It can show five things. The first is a set of raw segment patterns. The second is a display word written by software. The third is a frozen copy of an earlier conversion result. The fourth is the largest result seen so far. The fifth is the newest conversion result. Four control bits pick the source through a fixed priority chain. When a numeric result lies outside a pair of signed thresholds, the block puts out an out-of-range code instead of the number. This code is a flag plus a sign, and the digit formatter downstream draws it as a "1" or "-1" followed by dashes.

Conversion results arrive with a one-cycle valid strobe. While the hold control is set, the display stays frozen, but the block still tracks incoming results. When hold is released, the newest result appears at once. The raw segment registers are active-low: a 0 bit means the segment is lit. The block inverts them into active-high segment enables for the panel drive. Binary-to-decimal conversion and backplane drive belong to other blocks.

Top module: `display_src_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every output is 0. With all control bits at 0 after reset, the live result (reset value 0) is the source shown.
- R2: When `sel_seg` is 1, the other control bits do not matter. In that case `seg_mode` is 1, `disp_word`, `disp_oor` and `disp_neg` are 0, and `seg_on` is the bitwise inverse of `seg_raw` with bit 0 of every SEG_W-bit word forced to 0 (a 0 bit in `seg_raw` lights its segment). When `sel_seg` is 0, `seg_mode` is 0 and `seg_on` is all zeros.
- R3: When `sel_seg` is 0 and `sel_user` is 1, `disp_word` equals `user_data` and `disp_oor` and `disp_neg` are 0, whatever its value and whatever `hold_en` and `peak_en` are.
- R4: When `hold_en` is 1 (and neither higher source is selected), the shown value is the last result accepted while `hold_en` was 0. Results that arrive during hold do not change it.
- R5: Results keep being accepted while hold is active. When `hold_en` falls, the newest result is shown on the next cycle, without waiting for another conversion.
- R6: When `peak_en` is 1 (and no higher source is selected), the peak register is shown. On the cycle `peak_en` rises, the peak register restarts from the incoming result if one is valid, and otherwise from the last live result. After that it keeps the largest signed result. After reset it holds the most negative value.
- R7: A shown numeric value (hold, peak or live) that is strictly greater than `thr_hi` gives `disp_oor`=1, `disp_neg`=0 and `disp_word`=0. A value equal to `thr_hi` is shown as a number.
- R8: A shown numeric value that is strictly less than `thr_lo` gives `disp_oor`=1, `disp_neg`=1 and `disp_word`=0. A value equal to `thr_lo` is shown as a number.
- R9: All outputs are registered. The inputs sampled at a clock edge (controls, thresholds, user data, segment data, and a result with its valid strobe) decide the outputs right after that same edge.
- R10: `res_data` has no effect on any state or output in a cycle where `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_seg | input | 1 | Highest-priority select: raw segment mode |
| sel_user | input | 1 | Select the software-written display word |
| hold_en | input | 1 | Freeze the displayed result |
| peak_en | input | 1 | Show the peak register |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | DATA_W | Signed conversion result |
| thr_hi | input | DATA_W | Signed overrange threshold |
| thr_lo | input | DATA_W | Signed underrange threshold |
| user_data | input | DATA_W | Software display word |
| seg_raw | input | SEG_N*SEG_W | Active-low raw segment registers |
| disp_word | output | DATA_W | Selected display word |
| disp_oor | output | 1 | Out-of-range code in place of a number |
| disp_neg | output | 1 | Sign of the out-of-range code (1 = below) |
| seg_mode | output | 1 | Segment mode active |
| seg_on | output | SEG_N*SEG_W | Active-high segment enables |

## Verification
Each stored value shows up at the ports one cycle after it becomes the selected source. A wrong live, held or peak register therefore appears as a wrong `disp_word` or range flag on the first cycle that selects it. The bench visits every source often, with random control patterns, so a bad frozen or peak value cannot stay hidden for long. A missed restart of the peak register on an enable edge, or a wrong seed for it, shows up on the first cycle after `peak_en` rises. An off-by-one threshold comparison shows only at results exactly equal to a threshold, so these are driven on purpose.

// File: rtl/dsel_pkg.sv
// Shared types for the display source selector.
// Assumes: control bits are synchronous to the block clock.
package dsel_pkg;

    typedef enum logic [2:0] {
        SRC_SEG  = 3'd0,
        SRC_USER = 3'd1,
        SRC_HOLD = 3'd2,
        SRC_PEAK = 3'd3,
        SRC_LIVE = 3'd4
    } disp_src_e;

    // Fixed priority: segment > user > hold > peak > live.
    function automatic disp_src_e pick_src(input logic seg, input logic user,
                                           input logic hold, input logic peak);
        disp_src_e s;
        if (seg)       s = SRC_SEG;
        else if (user) s = SRC_USER;
        else if (hold) s = SRC_HOLD;
        else if (peak) s = SRC_PEAK;
        else           s = SRC_LIVE;
        return s;
    endfunction

endpackage

// File: rtl/dsel_result_track.sv
// Keeps the newest conversion result (live) and the frozen display copy (held).
// The held copy follows results only while hold is off, while live always does.
// Outputs the next-state values so the selector sees this cycle's update.
// Assumes: res_data is meaningful only when res_valid is 1.
module dsel_result_track #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid,
    input  logic signed [DATA_W-1:0] res_data,
    input  logic                     hold_en,
    output logic signed [DATA_W-1:0] live_q,
    output logic signed [DATA_W-1:0] live_nxt,
    output logic signed [DATA_W-1:0] held_nxt
);
    logic signed [DATA_W-1:0] held_q;

    // Next-state values for the live and held registers.
    always_comb begin
        live_nxt = res_valid ? res_data : live_q;
        held_nxt = (res_valid && !hold_en) ? res_data : held_q;
    end

    // State update with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            held_q <= '0;
        end else begin
            live_q <= live_nxt;
            held_q <= held_nxt;
        end
    end
endmodule

// File: rtl/dsel_peak_track.sv
// Tracks the largest signed result. Restarts on the rising edge of the peak
// enable from the incoming result, or from the last live value if none arrives.
// Assumes: live_q is the live register before this cycle's update.
module dsel_peak_track #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid,
    input  logic signed [DATA_W-1:0] res_data,
    input  logic signed [DATA_W-1:0] live_q,
    input  logic                     peak_en,
    output logic signed [DATA_W-1:0] peak_nxt
);
    localparam logic signed [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] peak_q;
    logic                     peak_en_d;
    logic                     restart;

    // Detect the enable edge and choose the next peak value.
    always_comb begin
        restart = peak_en && !peak_en_d;
        if (restart)
            peak_nxt = res_valid ? res_data : live_q;
        else if (res_valid && (res_data > peak_q))
            peak_nxt = res_data;
        else
            peak_nxt = peak_q;
    end

    // Peak and edge-detect registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q    <= MIN_VAL;
            peak_en_d <= 1'b0;
        end else begin
            peak_q    <= peak_nxt;
            peak_en_d <= peak_en;
        end
    end
endmodule

// File: rtl/dsel_range_cls.sv
// Classifies a signed value against an inclusive signed window.
// Assumes: thr_lo <= thr_hi for meaningful results; no ordering is enforced.
module dsel_range_cls #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] val,
    input  logic signed [DATA_W-1:0] thr_hi,
    input  logic signed [DATA_W-1:0] thr_lo,
    output logic                     over,
    output logic                     under
);
    // Strict comparisons: values on a threshold stay in range.
    always_comb begin
        over  = val > thr_hi;
        under = (val < thr_lo) && !over;
    end
endmodule

// File: rtl/dsel_seg_map.sv
// Turns active-low raw segment words into active-high enables.
// Bit 0 of each word is a pad position and is always driven low.
// Assumes: SEG_W >= 2.
module dsel_seg_map #(
    parameter int SEG_W = 16,
    parameter int SEG_N = 2
) (
    input  logic [SEG_N*SEG_W-1:0] raw,
    output logic [SEG_N*SEG_W-1:0] seg_en
);
    localparam logic [SEG_W-1:0] PAD_MASK = {{(SEG_W-1){1'b1}}, 1'b0};

    for (genvar w = 0; w < SEG_N; w++) begin : g_word
        // Invert one word and clear its pad bit.
        always_comb begin
            seg_en[w*SEG_W +: SEG_W] = ~raw[w*SEG_W +: SEG_W] & PAD_MASK;
        end
    end
endmodule

// File: rtl/display_src_sel.sv
// Top of the display source selector. Picks the display source by fixed
// priority, puts out-of-range codes in place of out-of-window numbers, and
// registers all outputs. The source state is read at its next-state value,
// so control changes and new results show right after the sampling edge.
// Assumes: all inputs are synchronous to clk.
module display_src_sel
    import dsel_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 16,
    parameter int SEG_N  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_seg,
    input  logic                      sel_user,
    input  logic                      hold_en,
    input  logic                      peak_en,
    input  logic                      res_valid,
    input  logic signed [DATA_W-1:0]  res_data,
    input  logic signed [DATA_W-1:0]  thr_hi,
    input  logic signed [DATA_W-1:0]  thr_lo,
    input  logic [DATA_W-1:0]         user_data,
    input  logic [SEG_N*SEG_W-1:0]    seg_raw,
    output logic [DATA_W-1:0]         disp_word,
    output logic                      disp_oor,
    output logic                      disp_neg,
    output logic                      seg_mode,
    output logic [SEG_N*SEG_W-1:0]    seg_on
);
    localparam int SEG_BITS = SEG_N * SEG_W;

    logic signed [DATA_W-1:0] live_q, live_nxt, held_nxt, peak_nxt;
    logic signed [DATA_W-1:0] num_val;
    logic                     is_over, is_under;
    logic [SEG_BITS-1:0]      seg_en_w;
    disp_src_e                src;

    logic [DATA_W-1:0]        word_d;
    logic                     oor_d, neg_d, segm_d;
    logic [SEG_BITS-1:0]      seg_d;

    dsel_result_track #(.DATA_W(DATA_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_valid(res_valid),
        .res_data (res_data),
        .hold_en  (hold_en),
        .live_q   (live_q),
        .live_nxt (live_nxt),
        .held_nxt (held_nxt)
    );

    dsel_peak_track #(.DATA_W(DATA_W)) u_peak (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_valid(res_valid),
        .res_data (res_data),
        .live_q   (live_q),
        .peak_en  (peak_en),
        .peak_nxt (peak_nxt)
    );

    dsel_range_cls #(.DATA_W(DATA_W)) u_rng (
        .val   (num_val),
        .thr_hi(thr_hi),
        .thr_lo(thr_lo),
        .over  (is_over),
        .under (is_under)
    );

    dsel_seg_map #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_seg (
        .raw   (seg_raw),
        .seg_en(seg_en_w)
    );

    // Resolve the active source and the numeric value it would show.
    always_comb begin
        src = pick_src(sel_seg, sel_user, hold_en, peak_en);
        case (src)
            SRC_HOLD: num_val = held_nxt;
            SRC_PEAK: num_val = peak_nxt;
            default:  num_val = live_nxt;
        endcase
    end

    // Build the next output set from the chosen source.
    always_comb begin
        word_d = '0;
        oor_d  = 1'b0;
        neg_d  = 1'b0;
        segm_d = 1'b0;
        seg_d  = '0;
        case (src)
            SRC_SEG: begin
                segm_d = 1'b1;
                seg_d  = seg_en_w;
            end
            SRC_USER: word_d = user_data;
            default: begin
                if (is_over) begin
                    oor_d = 1'b1;
                end else if (is_under) begin
                    oor_d = 1'b1;
                    neg_d = 1'b1;
                end else begin
                    word_d = num_val;
                end
            end
        endcase
    end

    // Output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_word <= '0;
            disp_oor  <= 1'b0;
            disp_neg  <= 1'b0;
            seg_mode  <= 1'b0;
            seg_on    <= '0;
        end else begin
            disp_word <= word_d;
            disp_oor  <= oor_d;
            disp_neg  <= neg_d;
            seg_mode  <= segm_d;
            seg_on    <= seg_d;
        end
    end
endmodule

// File: rtl/dsel_checker.sv
// Port-level properties of the display source selector, bound to the top.
// Assumes: same parameters as the bound instance.
module dsel_checker #(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 16,
    parameter int SEG_N  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_seg,
    input logic                     sel_user,
    input logic [DATA_W-1:0]        user_data,
    input logic [DATA_W-1:0]        disp_word,
    input logic                     disp_oor,
    input logic                     disp_neg,
    input logic                     seg_mode,
    input logic [SEG_N*SEG_W-1:0]   seg_on
);
    logic armed;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_seg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_mode |-> (disp_word == '0) && !disp_oor && !disp_neg);

    p_seg_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_mode |-> (seg_on == '0));

    p_seg_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(sel_seg)) |-> seg_mode);

    p_user_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!sel_seg && sel_user)) |->
            (disp_word == $past(user_data)) && !disp_oor);

    p_oor_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_oor |-> (disp_word == '0));

    p_neg_has_oor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_neg |-> disp_oor);

    // R2: pad bit of each segment word never lights.
    for (genvar w = 0; w < SEG_N; w++) begin : g_pad
        p_pad_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !seg_on[w*SEG_W]);
    end
endmodule

bind display_src_sel dsel_checker #(
    .DATA_W(DATA_W), .SEG_W(SEG_W), .SEG_N(SEG_N)
) u_dsel_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_seg  (sel_seg),
    .sel_user (sel_user),
    .user_data(user_data),
    .disp_word(disp_word),
    .disp_oor (disp_oor),
    .disp_neg (disp_neg),
    .seg_mode (seg_mode),
    .seg_on   (seg_on)
);

// File: tb/tb_display_src_sel.sv
module tb_display_src_sel;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               sel_seg, sel_user, hold_en, peak_en, res_valid;
    logic signed [15:0] res_data, thr_hi, thr_lo;
    logic [15:0]        user_data;
    logic [31:0]        seg_raw;
    logic [15:0]        disp_word;
    logic               disp_oor, disp_neg, seg_mode;
    logic [31:0]        seg_on;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0, m_go = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    display_src_sel #(.DATA_W(16), .SEG_W(16), .SEG_N(2)) dut (
        .clk(clk), .rst_n(rst_n), .sel_seg(sel_seg), .sel_user(sel_user),
        .hold_en(hold_en), .peak_en(peak_en), .res_valid(res_valid),
        .res_data(res_data), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .user_data(user_data), .seg_raw(seg_raw), .disp_word(disp_word),
        .disp_oor(disp_oor), .disp_neg(disp_neg), .seg_mode(seg_mode),
        .seg_on(seg_on)
    );

    // Behavioural reference model, advanced at each rising edge.
    int          m_live, m_held, m_peak;
    bit          m_pkd;
    logic [15:0] e_word;
    bit          e_oor, e_neg, e_segm;
    logic [31:0] e_seg;

    always @(posedge clk) begin : model
        int r, v;
        if (!rst_n) begin
            m_live = 0; m_held = 0; m_peak = -32768; m_pkd = 0;
            e_word = 0; e_oor = 0; e_neg = 0; e_segm = 0; e_seg = 0;
        end else begin
            r = int'(res_data);
            if (peak_en && !m_pkd) m_peak = res_valid ? r : m_live;
            else if (res_valid && r > m_peak) m_peak = r;
            if (res_valid) m_live = r;
            if (res_valid && !hold_en) m_held = r;
            m_pkd = peak_en;
            e_word = 0; e_oor = 0; e_neg = 0; e_segm = 0; e_seg = 0;
            if (sel_seg) begin
                e_segm = 1;
                e_seg  = ~seg_raw & 32'hFFFE_FFFE;
            end else if (sel_user) begin
                e_word = user_data;
            end else begin
                v = hold_en ? m_held : (peak_en ? m_peak : m_live);
                if (v > int'(thr_hi))      e_oor = 1;
                else if (v < int'(thr_lo)) begin e_oor = 1; e_neg = 1; end
                else                       e_word = v[15:0];
            end
        end
        m_go = 1;
    end

    // Compare the design with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (m_go && !done) begin
            n_chk++;
            if (disp_word !== e_word || disp_oor !== e_oor || disp_neg !== e_neg ||
                seg_mode !== e_segm || seg_on !== e_seg) begin
                n_fail++;
                $display("FAIL %s model: act word=%h oor=%b neg=%b seg=%b on=%h exp word=%h oor=%b neg=%b seg=%b on=%h",
                         cur_req, disp_word, disp_oor, disp_neg, seg_mode, seg_on,
                         e_word, e_oor, e_neg, e_segm, e_seg);
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic res(input int v);
        res_valid = 1'b1;
        res_data  = 16'(v);
        cyc();
        res_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; sel_seg = 0; sel_user = 0; hold_en = 0; peak_en = 0;
        res_valid = 0; res_data = 0; thr_hi = 16'sd19999; thr_lo = -16'sd20000;
        user_data = 16'h5A5A; seg_raw = 32'h0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        chk("R1 reset", {disp_word, disp_oor, disp_neg, seg_mode, seg_on}, 0);
        rst_n = 1;
        cyc();
        chk("R1 after reset", {disp_word, disp_oor, seg_mode, seg_on}, 0);

        cur_req = "R9";
        res(100);
        chk("R9 live latency", disp_word, 100);
        cur_req = "R10";
        res_data = 555;
        cyc();
        chk("R10 data without valid", disp_word, 100);

        cur_req = "R7";
        res(20000);
        chk("R7 over", {disp_word, disp_oor, disp_neg}, {16'h0, 2'b10});
        res(19999);
        chk("R7 at limit", {disp_word, disp_oor}, {16'd19999, 1'b0});
        cur_req = "R8";
        res(-20001);
        chk("R8 under", {disp_word, disp_oor, disp_neg}, {16'h0, 2'b11});
        res(-20000);
        chk("R8 at limit", {disp_word, disp_oor}, {16'hB1E0, 1'b0});

        cur_req = "R4";
        res(300);
        hold_en = 1;
        res(400);
        chk("R4 hold freeze", disp_word, 300);
        res(500);
        chk("R4 hold still", disp_word, 300);
        cur_req = "R5";
        hold_en = 0;
        cyc();
        chk("R5 release shows newest", disp_word, 500);

        cur_req = "R6";
        peak_en = 1;
        res(50);
        chk("R6 restart seed", disp_word, 50);
        res(40);
        chk("R6 smaller ignored", disp_word, 50);
        res(70);
        chk("R6 new peak", disp_word, 70);
        res(-10);
        chk("R6 keeps max", disp_word, 70);
        peak_en = 0;
        cyc();
        chk("R6 live after peak", disp_word, 16'hFFF6);
        peak_en = 1;
        cyc();
        chk("R6 seed from live", disp_word, 16'hFFF6);
        res(5);
        chk("R6 rise after seed", disp_word, 5);

        cur_req = "R3";
        hold_en = 1; sel_user = 1; user_data = 16'h7FFF;
        cyc();
        chk("R3 user over priority", {disp_word, disp_oor}, {16'h7FFF, 1'b0});

        cur_req = "R2";
        sel_seg = 1; seg_raw = 32'h1234_5679;
        cyc();
        chk("R2 segment map", {seg_on, seg_mode, disp_word}, {32'hEDCA_A986, 1'b1, 16'h0});
        sel_seg = 0;
        cyc();
        chk("R2 segment off", {seg_on, seg_mode}, {32'h0, 1'b0});
        sel_user = 0; hold_en = 0; peak_en = 0;

        cur_req = "R9";
        for (int i = 0; i < 4000; i++) begin
            sel_seg   = ($urandom_range(9) == 0);
            sel_user  = ($urandom_range(7) == 0);
            hold_en   = ($urandom_range(3) == 0);
            if ($urandom_range(5) == 0) peak_en = ~peak_en;
            res_valid = $urandom_range(1);
            res_data  = 16'($urandom_range(50000) - 25000);
            user_data = 16'($urandom);
            seg_raw   = $urandom;
            if (i == 2000) begin thr_hi = 16'sd100; thr_lo = -16'sd100; end
            cyc();
        end
        finish_run();
    end
endmodule